// File: doc/BRIEF.md
# Serial Nibble Input Capture Port

This block collects a 4-bit serial data stream into a 16-stage nibble shift register. It keeps the newest 16 nibbles and drops older ones, so the input can be clocked without limit. A falling edge on the write-transfer strobe copies the whole register into a holding latch. The latch drives a 64-bit word toward a memory array. Because the latch is separate from the shifter, serial input keeps streaming while an earlier block of nibbles waits to be written.

The shift clock, the transfer strobe and the memory-enable strobe are all level inputs. They are sampled in one system clock domain. Edges are found by comparing each input with a registered copy of itself. A write commit is a rising edge of the memory-enable strobe while the 2-bit mode input carries the write code. A commit tells the port that the latch has been consumed, and the valid flag drops.

Top module: `nibble_capture_port`

## Requirements
- R1: While rst_ni is low and after its release, word_o is all zeros and valid_o is 0.
- R2: A nibble is taken from data_i only in a cycle where shift_clk_i is high after being low in the previous cycle. Holding shift_clk_i high captures nothing more.
- R3: The shifter holds exactly 16 nibbles. After more than 16 captures, only the 16 most recent remain. Before 16 captures since reset, the missing older positions read as zero.
- R4: In the latched word, nibble k sits at bits [4k+3:4k]. Nibble 0 is the oldest captured nibble and nibble 15 is the newest.
- R5: A cycle where xfer_i is low after being high copies the shifter into the latch, and the copy shows on word_o one clock later. A rising edge of xfer_i, or any cycle without a falling edge, leaves word_o unchanged.
- R6: When a shift edge and a transfer falling edge fall in the same cycle, the latched word includes the nibble captured in that cycle.
- R7: Shifting continues across a transfer, so a stream split by transfers loses no nibble.
- R8: valid_o goes to 1 one clock after each transfer falling edge.
- R9: A rising edge of commit_i with mode_i equal to 2'b10 (bit 1 high, bit 0 low) clears valid_o one clock later. A rising edge with any other mode_i value leaves valid_o unchanged. A commit never changes word_o.
- R10: If a transfer falling edge and a write commit occur in the same cycle, valid_o ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_clk_i | input | 1 | Serial shift clock level; a rising edge captures a nibble |
| data_i | input | 4 | Serial nibble input |
| xfer_i | input | 1 | Write-transfer strobe; a falling edge loads the latch |
| commit_i | input | 1 | Memory-enable strobe; a rising edge is a commit request |
| mode_i | input | 2 | Mode code; 2'b10 marks a write commit |
| word_o | output | 64 | Holding latch contents, nibble 0 oldest in the low bits |
| valid_o | output | 1 | Latch holds data not yet committed |

## Verification
The bench sweeps the number of nibbles shifted between transfers from zero to twenty. This covers the partly filled shifter after reset, the exact fill and the overflow case. A design that kept the oldest nibbles, or that reversed the packing, returns a rotated or mirrored word. A shift edge placed in the same cycle as the transfer edge catches a latch that loads the registered shifter value and misses the newest nibble. Holding the shift clock high for several cycles catches a design that captures on the level instead of the edge. Commits with each non-write mode code catch a port that clears valid on any enable edge. A commit in the same cycle as a transfer catches a port that lets the clear win.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    MODE_RD_A = 2'b00,
    MODE_RD_B = 2'b01,
    MODE_WR   = 2'b10,
    MODE_RFSH = 2'b11
  } cap_mode_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = lvl_i & ~lvl_q;
    end else begin : g_fall
      assign edge_o = ~lvl_i & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/cap_nib_shifter.sv
module cap_nib_shifter #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [NIB_W-1:0]  data_i,
  output logic [WORD_W-1:0] next_o
);
  logic [NIB_W-1:0] stage_q [DEPTH];
  logic [NIB_W-1:0] stage_d [DEPTH];

  // newest enters the top stage; stage 0 holds the oldest
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == DEPTH - 1) begin : g_top
        assign stage_d[g] = shift_i ? data_i : stage_q[g];
      end else begin : g_mid
        assign stage_d[g] = shift_i ? stage_q[g+1] : stage_q[g];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_d[g];
      end

      assign next_o[g*NIB_W +: NIB_W] = stage_d[g];
    end
  endgenerate
endmodule

// File: rtl/cap_hold_latch.sv
module cap_hold_latch #(
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (load_i) word_o <= word_i;
      // a fresh load outranks a simultaneous commit
      if (load_i)        valid_o <= 1'b1;
      else if (commit_i) valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nibble_capture_port.sv
module nibble_capture_port #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_clk_i,
  input  logic [NIB_W-1:0]  data_i,
  input  logic              xfer_i,
  input  logic              commit_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  import cap_pkg::*;

  logic shift_rise, xfer_fall, commit_rise, wr_commit;
  logic [WORD_W-1:0] sr_next;

  cap_edge_det #(.RISE(1'b1)) u_shift_edge (
    .clk_i, .rst_ni, .lvl_i(shift_clk_i), .edge_o(shift_rise)
  );
  cap_edge_det #(.RISE(1'b0)) u_xfer_edge (
    .clk_i, .rst_ni, .lvl_i(xfer_i), .edge_o(xfer_fall)
  );
  cap_edge_det #(.RISE(1'b1)) u_commit_edge (
    .clk_i, .rst_ni, .lvl_i(commit_i), .edge_o(commit_rise)
  );

  assign wr_commit = commit_rise && (cap_mode_e'(mode_i) == MODE_WR);

  cap_nib_shifter #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_shifter (
    .clk_i, .rst_ni, .shift_i(shift_rise), .data_i, .next_o(sr_next)
  );

  cap_hold_latch #(.WORD_W(WORD_W)) u_latch (
    .clk_i, .rst_ni, .load_i(xfer_fall), .commit_i(wr_commit),
    .word_i(sr_next), .word_o, .valid_o
  );
endmodule

// File: rtl/nibble_capture_port_chk.sv
module nibble_capture_port_chk #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              shift_clk_i,
  input logic [NIB_W-1:0]  data_i,
  input logic              xfer_i,
  input logic              commit_i,
  input logic [1:0]        mode_i,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o
);
  logic sh_q, xf_q, cm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {sh_q, xf_q, cm_q} <= '0;
    else         {sh_q, xf_q, cm_q} <= {shift_clk_i, xfer_i, commit_i};
  end

  wire c_xf = xf_q & ~xfer_i;
  wire c_sh = shift_clk_i & ~sh_q;
  wire c_cm = commit_i & ~cm_q;

  always_comb if (!rst_ni) a_r1_reset_clear : assert (valid_o == 1'b0 && word_o == '0);

  a_r5_hold_word : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_xf |=> $stable(word_o));
  a_r6_newest_in : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_xf && c_sh) |=> word_o[WORD_W-1 -: NIB_W] == $past(data_i));
  a_r8_valid_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_xf |=> valid_o);
  a_r9_write_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cm && mode_i == 2'b10 && !c_xf) |=> !valid_o);
  a_r9_other_keep : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_xf && !(c_cm && mode_i == 2'b10)) |=> $stable(valid_o));
endmodule

bind nibble_capture_port nibble_capture_port_chk #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/nibble_capture_port_tb_top.sv
`timescale 1ns/1ps
module nibble_capture_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_clk = 1'b0, xfer = 1'b0, commit = 1'b0;
  logic [3:0] data = '0;
  logic [1:0] mode = 2'b00;
  logic [63:0] word;
  logic valid;

  int n_chk = 0, n_fail = 0;
  logic [3:0] hist [0:1023];
  int n_hist = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nibble_capture_port dut_i (
    .clk_i(clk), .rst_ni, .shift_clk_i(shift_clk), .data_i(data),
    .xfer_i(xfer), .commit_i(commit), .mode_i(mode), .word_o(word), .valid_o(valid)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // newest 16 nibbles, oldest at bits [3:0]
  function automatic logic [63:0] expected_word();
    logic [63:0] w = '0;
    for (int k = 0; k < 16; k++) begin
      int idx = n_hist - 16 + k;
      if (idx >= 0) w[k*4 +: 4] = hist[idx];
    end
    return w;
  endfunction

  task automatic shift_nib(logic [3:0] d);
    data = d; shift_clk = 1'b1; tick();
    hist[n_hist] = d; n_hist++;
    shift_clk = 1'b0; tick();
  endtask

  task automatic do_xfer();
    xfer = 1'b1; tick();
    xfer = 1'b0; tick();
  endtask

  task automatic do_commit(logic [1:0] m);
    mode = m; commit = 1'b1; tick();
    commit = 1'b0; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] w_before;
    tick(); tick();
    check("R1 word", word, 64'h0);
    check("R1 valid", {63'b0, valid}, 64'h1 & 64'h0);
    rst_ni = 1'b1; tick();
    check("R1 word after release", word, 64'h0);
    check("R1 valid after release", {63'b0, valid}, 64'h0);

    // R3 R4 R5 R8: sweep fill lengths, partial fill and overflow
    for (int len = 0; len <= 20; len++) begin
      for (int i = 0; i < len; i++) shift_nib(4'((len * 5 + i * 7 + 3) & 15));
      do_xfer();
      check($sformatf("R3 R4 R5 len=%0d", len), word, expected_word());
      check($sformatf("R8 len=%0d", len), {63'b0, valid}, 64'h1);
      if (len % 3 == 0) begin
        do_commit(2'b10);
        check("R9 write commit clears", {63'b0, valid}, 64'h0);
        check("R9 commit keeps word", word, expected_word());
      end
    end

    // R5: rising transfer edge and shifts without transfer leave word alone
    w_before = word;
    xfer = 1'b1; tick(); tick();
    check("R5 rising edge no load", word, w_before);
    shift_nib(4'hA); shift_nib(4'h5);
    check("R5 hold while shifting", word, w_before);
    xfer = 1'b0; tick();
    check("R5 fall loads", word, expected_word());

    // R9: non-write modes do not clear
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      do_xfer();
      do_commit(2'(m));
      check($sformatf("R9 mode=%0d keeps valid", m), {63'b0, valid}, 64'h1);
      check($sformatf("R9 mode=%0d keeps word", m), word, expected_word());
    end
    do_commit(2'b10);
    check("R9 clear", {63'b0, valid}, 64'h0);

    // R2: held level captures only once
    data = 4'h3; shift_clk = 1'b1; tick();
    hist[n_hist] = 4'h3; n_hist++;
    for (int i = 0; i < 4; i++) begin data = 4'(9 + i); tick(); end
    shift_clk = 1'b0; tick();
    do_xfer();
    check("R2 single capture on held level", word, expected_word());

    // R6: shift edge and transfer edge in the same cycle
    for (int v = 0; v < 16; v++) begin
      xfer = 1'b1; tick();
      data = 4'(v ^ 4'h6); shift_clk = 1'b1; xfer = 1'b0; tick();
      hist[n_hist] = 4'(v ^ 4'h6); n_hist++;
      check($sformatf("R6 same cycle v=%0d", v), word, expected_word());
      shift_clk = 1'b0; tick();
    end

    // R7: transfers interleaved with a continuous stream
    for (int blk = 0; blk < 4; blk++) begin
      for (int i = 0; i < 16; i++) begin
        data = 4'((blk * 3 + i * 11) & 15);
        shift_clk = 1'b1;
        xfer = (i == 7);
        tick();
        hist[n_hist] = data; n_hist++;
        shift_clk = 1'b0; xfer = 1'b0;
        tick();
      end
      xfer = 1'b1; tick(); xfer = 1'b0; tick();
      check($sformatf("R7 stream block %0d", blk), word, expected_word());
    end

    // R10: transfer and write commit in the same cycle
    do_commit(2'b10);
    shift_nib(4'hE);
    xfer = 1'b1; tick();
    xfer = 1'b0; mode = 2'b10; commit = 1'b1; tick();
    check("R10 valid kept", {63'b0, valid}, 64'h1);
    check("R10 word loaded", word, expected_word());
    commit = 1'b0; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule